// File: doc/BRIEF.md
# MDIO PHY Status Poller

This block keeps duplex mode and link state current for two MII ports. Two straps per function are captured while reset is held. One pair says whether each port takes its duplex from auto-negotiation. The other pair gives the fixed duplex for any port that does not negotiate.

If at least one port negotiates, the block drives its own MDC clock and runs MDIO read frames without stopping. It reads three registers from each of the two PHYs in turn. From the status register it takes the link state and the negotiation-complete flag. It then reduces the local advertisement and the partner ability words to a single full or half decision.

When no port negotiates, the serial interface stays quiet. The block reports link down unless software forces link pass through the override input. Port speed is not handled here, because the PHY clock frequency sets it.

Top module: `phy_status_poller`

## Requirements
- R1: Both strap pairs (`strap_an_en`, `strap_duplex`) are captured on every clock while `rst_n` is low. Changes on these inputs after reset has been released have no effect.
- R2: For a port whose negotiation strap is 0, `duplex_full[p]` equals the captured `strap_duplex[p]`, where 1 means full and 0 means half.
- R3: For a negotiating port, duplex is updated when a read of register 5 completes, and only if the most recent register 1 read of that PHY had bit 5 set. The value is full if bit 8 of (register 4 AND register 5) is set, or if bits 8 and 7 of that AND are both clear and bit 6 is set; otherwise it is half. Otherwise the previous value is held. The value after reset is half (0).
- R4: With both negotiation straps at 0, `mdc` stays low, `mdio_oe` stays low, and the link seen from the PHYs is down.
- R5: Polling reads PHY address 1 registers 1, 4 and 5 in that order, then the same three registers at PHY address 2, and repeats this for as long as polling is active. Port 0 maps to address 1 and port 1 to address 2.
- R6: Each read frame is 64 MDC periods long and has this layout:
  - 32 ones;
  - the bits 0,1,1,0 (start, then read opcode);
  - the 5-bit PHY address, MSB first;
  - the 5-bit register address, MSB first;
  - 2 turnaround periods;
  - 16 data bits, MSB first.

  `mdio_o` changes only on MDC falling edges. `mdio_oe` is high for the first 46 bits and low for the last 18. `mdio_i` is sampled at MDC rising edges.
- R7: While polling, `link_up[p]` follows bit 2 of the last register 1 read from port p's PHY. This holds for both ports, whatever each port's own negotiation strap says.
- R8: While `force_link` is high, both `link_up` bits are 1.
- R9: Each MDC level lasts exactly `MDC_DIV` system clocks, so one MDC period is 2*`MDC_DIV` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; straps are captured while low |
| strap_an_en | input | 2 | Per-port negotiation enable strap |
| strap_duplex | input | 2 | Per-port fixed duplex strap (1 = full) |
| force_link | input | 1 | Forces both link outputs high |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven toward the PHYs |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Management data read back from the PHYs |
| duplex_full | output | 2 | Per-port duplex (1 = full) |
| link_up | output | 2 | Per-port link state |

## Verification
Duplex and link results are registered on the same system clock edge that raises MDC for the last data bit of a frame. The bench's PHY model decodes each frame on MDC rising edges as it samples them at the falling system clock edge. It applies its expected update at that same half-cycle before it compares `duplex_full` and `link_up`, so the two agree on every clock. The override acts combinationally, so it is checked in the same half-cycle in which it is applied. Header bits and `mdio_oe` are compared only at MDC rising edges, which is where a PHY would sample them.

// File: rtl/phy_status_poller.sv
module phy_status_poller #(
  parameter int          MDC_DIV   = 25,
  parameter logic [4:0]  PHY_ADDR0 = 5'd1,
  parameter logic [4:0]  PHY_ADDR1 = 5'd2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_an_en,
  input  logic [1:0] strap_duplex,
  input  logic       force_link,
  output logic       mdc,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic       mdio_i,
  output logic [1:0] duplex_full,
  output logic [1:0] link_up
);

  localparam int CW = (MDC_DIV > 1) ? $clog2(MDC_DIV) : 1;

  logic [CW-1:0]   div_cnt;
  logic [5:0]      bitc;
  logic [1:0]      step;
  logic            port;
  logic [15:0]     shreg;
  logic [1:0]      an_q, dup_strap_q, dup_an, link_q, anc_q;
  logic [1:0][2:0] adv_q;

  wire        poll_en = |an_q;
  wire        tick    = (div_cnt == CW'(MDC_DIV - 1));
  wire        rise    = tick & ~mdc;
  wire        fall    = tick & mdc;
  wire        last    = (bitc == 6'd63);
  wire [15:0] rdata   = {shreg[14:0], mdio_i};
  wire [4:0]  phy_sel = port ? PHY_ADDR1 : PHY_ADDR0;
  wire [4:0]  reg_sel = (step == 2'd0) ? 5'd1 : (step == 2'd1) ? 5'd4 : 5'd5;
  wire [63:0] frame   = {32'hFFFF_FFFF, 4'b0110, phy_sel, reg_sel, 18'h3FFFF};

  function automatic logic resolve(input logic [2:0] c);
    return c[2] | (~c[1] & c[0]);
  endfunction

  assign mdio_o      = frame[6'd63 - bitc];
  assign mdio_oe     = poll_en & (bitc < 6'd46);
  assign duplex_full = (an_q & dup_an) | (~an_q & dup_strap_q);
  assign link_up     = link_q | {2{force_link}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      an_q        <= strap_an_en;
      dup_strap_q <= strap_duplex;
      div_cnt     <= '0;
      mdc         <= 1'b0;
      bitc        <= '0;
      step        <= '0;
      port        <= 1'b0;
      shreg       <= '0;
      dup_an      <= '0;
      link_q      <= '0;
      anc_q       <= '0;
      adv_q       <= '0;
    end else if (poll_en) begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) mdc <= ~mdc;
      if (rise) begin
        shreg <= rdata;
        if (last) begin
          case (step)
            2'd0: begin
              link_q[port] <= rdata[2];
              anc_q[port]  <= rdata[5];
            end
            2'd1: adv_q[port] <= rdata[8:6];
            2'd2: if (anc_q[port]) dup_an[port] <= resolve(adv_q[port] & rdata[8:6]);
            default: ;
          endcase
        end
      end
      if (fall) begin
        bitc <= bitc + 1'b1;
        if (last) begin
          if (step == 2'd2) begin
            step <= '0;
            port <= ~port;
          end else begin
            step <= step + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/phy_status_poller_chk.sv
module phy_status_poller_chk #(
  parameter int MDC_DIV = 25
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] an_q,
  input logic       force_link,
  input logic       mdc,
  input logic       mdio_oe,
  input logic [1:0] duplex_full,
  input logic [1:0] link_up
);

  logic mdc_prev;
  int   hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_prev <= 1'b0;
      hold     <= 0;
    end else begin
      mdc_prev <= mdc;
      hold     <= (mdc != mdc_prev) ? 1 : hold + 1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (an_q == 2'b00) |-> (!mdc && !mdio_oe)); // R4
  AST_FORCE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    force_link |-> (link_up == 2'b11)); // R8
  AST_STRAP_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
    !an_q[0] |=> $stable(duplex_full[0])); // R2
  AST_STRAP_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
    !an_q[1] |=> $stable(duplex_full[1])); // R2
  AST_DUPLEX_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duplex_full) |-> $rose(mdc)); // R3
  AST_MDC_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_prev) |-> (hold == MDC_DIV)); // R9

endmodule

bind phy_status_poller phy_status_poller_chk #(.MDC_DIV(MDC_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .an_q(an_q), .force_link(force_link),
  .mdc(mdc), .mdio_oe(mdio_oe), .duplex_full(duplex_full), .link_up(link_up)
);

// File: tb/phy_status_poller_test.sv
module phy_status_poller_test;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0, force_link = 1'b0, mdio_i = 1'b1;
  logic [1:0] strap_an_en = 2'b00, strap_duplex = 2'b00;
  logic mdc, mdio_o, mdio_oe;
  logic [1:0] duplex_full, link_up;

  always #4 clk = ~clk;

  phy_status_poller #(.MDC_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .strap_an_en(strap_an_en), .strap_duplex(strap_duplex),
    .force_link(force_link), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i), .duplex_full(duplex_full), .link_up(link_up));

  int checks = 0, fails = 0, cycles = 0;
  logic [15:0] phy_stat[2], phy_adv[2], phy_lpa[2];
  logic [1:0] an_s, dup_s, exp_link, exp_anc, exp_dup;
  logic [15:0] exp_adv[2];
  logic [15:0] resp;
  logic model_on = 1'b0, mdc_seen, first_rise;
  int r, frames, gap;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic logic full_of(input logic [15:0] a, input logic [15:0] l);
    logic [15:0] c;
    c = a & l;
    if (c[8]) return 1'b1;
    if (c[7]) return 1'b0;
    return c[6];
  endfunction

  function automatic logic [4:0] reg_of(input int n);
    case (n % 3)
      0: return 5'd1;
      1: return 5'd4;
      default: return 5'd5;
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (model_on) begin
      int p;
      logic [45:0] hdr;
      p = (frames / 3) % 2;
      gap++;
      if (an_s == 2'b00) begin
        chk({31'd0, mdc}, 0, "R4 mdc idle");
        chk({31'd0, mdio_oe}, 0, "R4 oe idle");
      end else if (mdc && !mdc_seen) begin
        if (!first_rise) chk(gap, 2 * DIV, "R9 mdc period");
        first_rise = 1'b0;
        gap = 0;
        hdr = {32'hFFFF_FFFF, 4'b0110, (p == 0) ? 5'd1 : 5'd2, reg_of(frames)};
        chk({31'd0, mdio_oe}, (r < 46) ? 1 : 0, "R6 oe");
        if (r < 46) chk({31'd0, mdio_o}, {31'd0, hdr[45 - r]}, "R5 R6 header bit");
        if (r == 63) begin
          case (reg_of(frames))
            5'd1: begin exp_link[p] = resp[2]; exp_anc[p] = resp[5]; end
            5'd4: exp_adv[p] = resp;
            default: if (exp_anc[p]) exp_dup[p] = full_of(exp_adv[p], resp);
          endcase
          frames++;
          r = 0;
        end else begin
          r++;
          if (r == 46) begin
            p = (frames / 3) % 2;
            resp = (reg_of(frames) == 5'd1) ? phy_stat[p] :
                   (reg_of(frames) == 5'd4) ? phy_adv[p] : phy_lpa[p];
          end
        end
        mdio_i = (r >= 48) ? resp[63 - r] : 1'b1;
      end
      mdc_seen = mdc;
      for (int q = 0; q < 2; q++) begin
        chk({31'd0, duplex_full[q]}, {31'd0, an_s[q] ? exp_dup[q] : dup_s[q]}, "R2 R3 duplex");
        chk({31'd0, link_up[q]}, {31'd0, force_link | exp_link[q]}, "R7 R8 link");
      end
    end
  end

  task automatic do_reset(input logic [1:0] an, input logic [1:0] dup);
    @(posedge clk); #1;
    model_on = 1'b0;
    rst_n = 1'b0;
    strap_an_en = an;
    strap_duplex = dup;
    repeat (3) @(posedge clk);
    #1;
    an_s = an; dup_s = dup;
    exp_link = 0; exp_anc = 0; exp_dup = 0;
    exp_adv[0] = 0; exp_adv[1] = 0;
    r = 0; frames = 0; gap = 0;
    mdc_seen = 1'b0; first_rise = 1'b1; mdio_i = 1'b1;
    rst_n = 1'b1;
    model_on = 1'b1;
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = frames + n;
    while (frames < target) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      phy_stat[i] = 0; phy_adv[i] = 0; phy_lpa[i] = 0;
    end
    do_reset(2'b00, 2'b10);
    @(negedge clk);
    chk({30'd0, duplex_full}, 2, "R2 reset duplex");
    chk({30'd0, link_up}, 0, "R4 link down");
    @(posedge clk); #1 strap_duplex = 2'b01; strap_an_en = 2'b11;
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk({30'd0, duplex_full}, 2, "R1 straps ignored after reset");
    chk({31'd0, mdc}, 0, "R1 no polling after late strap");
    @(posedge clk); #1 force_link = 1'b1;
    @(negedge clk);
    chk({30'd0, link_up}, 3, "R8 force link");
    @(posedge clk); #1 force_link = 1'b0;

    phy_stat[0] = 16'h0024; phy_adv[0] = 16'h01E1; phy_lpa[0] = 16'h0061;
    phy_stat[1] = 16'h0000; phy_adv[1] = 16'h01E1; phy_lpa[1] = 16'h01E1;
    do_reset(2'b01, 2'b11);
    wait_frames(7);
    chk({30'd0, duplex_full}, 3, "R3 10 full common");
    chk({30'd0, link_up}, 1, "R7 link from status");
    phy_lpa[0] = 16'h0021; phy_stat[1] = 16'h0004;
    wait_frames(12);
    chk({30'd0, duplex_full}, 2, "R3 only 10 half common");
    chk({30'd0, link_up}, 3, "R7 link on non-negotiating port");

    phy_stat[0] = 16'h0024; phy_adv[0] = 16'h01E1; phy_lpa[0] = 16'h00E1;
    phy_stat[1] = 16'h0024; phy_adv[1] = 16'h01E1; phy_lpa[1] = 16'h01E1;
    do_reset(2'b11, 2'b00);
    wait_frames(6);
    chk({30'd0, duplex_full}, 2, "R3 100 half beats 10 full");
    phy_stat[1] = 16'h0004; phy_lpa[1] = 16'h0021; phy_lpa[0] = 16'h0141;
    wait_frames(12);
    chk({30'd0, duplex_full}, 3, "R3 held without complete and 100 full");
    @(posedge clk); #1 force_link = 1'b1;
    @(negedge clk);
    chk({30'd0, link_up}, 3, "R8 force while polling");
    @(posedge clk); #1 force_link = 1'b0;
    wait_frames(2);
    chk(frames, 20, "R5 polling continues");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule